// File: doc/BRIEF.md
# MDIO Station-Management Master

This block runs one management transaction at a time against the registers of an external Ethernet PHY, using the two-wire MDC/MDIO serial interface. The host presents a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value, then pulses `start`. The block raises `busy`, produces the MDC clock by dividing the system clock, and shifts out a 64-bit management frame on the data line. When the frame ends it pulses `done`. For a read, the word returned by the PHY is available on `rd_data` at that point.

MDIO is a shared bidirectional line. The block therefore drives an output value and an output enable into an external tri-state pad, and it reads the pad's input value back. At the two turnaround bit times of a read, it stops driving the line so that the PHY can take it. It then captures the 16 reply bits. Between frames the line is not driven and is held high by the board's pull-up, and MDC rests high.

The MDC half-period is set in system clocks by the `HALF_DIV` parameter. Choose a value that keeps MDC at or below 2.5 MHz for the system clock in use.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no frame is in progress, `mdc` is 1, `mdio_oe` is 0, `busy` is 0 and `done` is 0.
- R2: Every frame starts with 32 bit times in which the master drives MDIO to 1.
- R3: The next two bits are a start code of 0 then 1. The two bits after it are the operation code: 1 then 0 for a read, 0 then 1 for a write.
- R4: The operation code is followed by the 5-bit PHY address and then the 5-bit register address, each sent most significant bit first.
- R5: `mdio_o` and `mdio_oe` change only on the system clock edge at which `mdc` falls, or on the edge that ends the frame. They hold steady for the whole time `mdc` is high.
- R6: Each bit time is `HALF_DIV` system clocks with `mdc` at 0, followed by `HALF_DIV` clocks with `mdc` at 1. A frame has exactly 64 rising edges of `mdc`, and its first falling edge comes on the clock edge that accepts `start`.
- R7: In a write frame, the master drives the turnaround bits as 1 then 0 and then the 16 bits of `wr_data`, most significant bit first.
- R8: In a read frame, `mdio_oe` is 0 for bit times 46 to 63, counted from 0 at the first preamble bit. `mdio_i` is sampled on the system clock edge at which `mdc` rises, in bit times 48 to 63. The samples are assembled most significant bit first and appear on `rd_data` when `done` is 1.
- R9: `busy` goes high on the edge that accepts `start`. It falls on the edge that ends the frame, and `done` is high for exactly that one following cycle. A `start` that arrives while `busy` is high has no effect on the frame in progress or on its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transaction (accepted only while not busy) |
| rd_sel | input | 1 | 1 selects a read, 0 a write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Value to write |
| rd_data | output | 16 | Word captured by the last read |
| done | output | 1 | One-cycle end-of-transaction pulse |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Value driven to the MDIO pad |
| mdio_oe | output | 1 | Output enable of the MDIO pad |
| mdio_i | input | 1 | Value read from the MDIO pad |

## Verification
The bench instantiates the block with `HALF_DIV` set to 3. Each bit time is then six clocks and a whole frame takes 385 clocks, so several reads and writes fit in a short run. A half-period above one clock leaves room to show that an output or an input change inside a phase is neither taken early nor sampled late. The bench's PHY model inverts its reply bit right after every MDC rise. Any read sample taken away from the rising edge therefore gives a wrong word.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W      = 5;
  localparam int DATA_W      = 16;
  localparam int PRE_BITS    = 32;
  localparam int FRAME_BITS  = PRE_BITS + 2 + 2 + 2*ADDR_W + 2 + DATA_W;
  localparam int RELEASE_BIT = PRE_BITS + 2 + 2 + 2*ADDR_W;
  localparam int RD_FIRST    = RELEASE_BIT + 2;

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mdio_opc_e;

  function automatic logic [FRAME_BITS-1:0] pack_frame(
    input logic              rd,
    input logic [ADDR_W-1:0] pa,
    input logic [ADDR_W-1:0] ra,
    input logic [DATA_W-1:0] wd
  );
    mdio_opc_e opc;
    opc = rd ? OPC_READ : OPC_WRITE;
    return {{PRE_BITS{1'b1}}, 2'b01, opc, pa, ra, 2'b10, wd};
  endfunction
endpackage

// File: rtl/mdio_mdc_timer.sv
module mdio_mdc_timer #(
  parameter int HALF_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic active,
  input  logic last_bit,
  output logic mdc,
  output logic rise_tick,
  output logic bit_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          phase_end;

  assign phase_end = active && (cnt_q == CNT_MAX);
  assign rise_tick = phase_end && !mdc_q;
  assign bit_tick  = phase_end && mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (kick) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (active) begin
      if (phase_end) begin
        cnt_d = '0;
        if (!mdc_q)        mdc_d = 1'b1;
        else if (!last_bit) mdc_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
      mdc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

  // R1: clock rests high outside a frame
  a_r1_idle_mdc_high: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> mdc_q);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit_tick,
  output logic              kick,
  output logic              busy,
  output logic              last_bit,
  output logic              is_rd,
  output logic [$clog2(FRAME_BITS)-1:0] bit_idx,
  output logic              mdo,
  output logic              oe,
  output logic              done
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(RELEASE_BIT);

  logic [FRAME_BITS-1:0] sh_q, sh_d, fresh;
  logic [IDX_W-1:0]      idx_q, idx_d, idx_nx;
  logic busy_q, busy_d, rd_q, rd_d, mdo_q, mdo_d, oe_q, oe_d, done_q, done_d;

  assign kick     = start && !busy_q;
  assign last_bit = (idx_q == LAST_IDX);
  assign fresh    = pack_frame(rd_sel, phy_addr, reg_addr, wr_data);
  assign idx_nx   = idx_q + 1'b1;

  always_comb begin
    sh_d   = sh_q;
    idx_d  = idx_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    mdo_d  = mdo_q;
    oe_d   = oe_q;
    done_d = 1'b0;
    if (kick) begin
      busy_d = 1'b1;
      rd_d   = rd_sel;
      idx_d  = '0;
      mdo_d  = fresh[FRAME_BITS-1];
      sh_d   = {fresh[FRAME_BITS-2:0], 1'b1};
      oe_d   = 1'b1;
    end else if (busy_q && bit_tick) begin
      if (last_bit) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        oe_d   = 1'b0;
        mdo_d  = 1'b1;
      end else begin
        idx_d = idx_nx;
        mdo_d = sh_q[FRAME_BITS-1];
        sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
        oe_d  = !(rd_q && (idx_nx >= REL_IDX));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      idx_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      mdo_q  <= 1'b1;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
      mdo_q  <= mdo_d;
      oe_q   <= oe_d;
      done_q <= done_d;
    end
  end

  assign busy    = busy_q;
  assign is_rd   = rd_q;
  assign bit_idx = idx_q;
  assign mdo     = mdo_q;
  assign oe      = oe_q;
  assign done    = done_q;

  // R8: line released through turnaround and reply in a read
  a_r8_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && idx_q >= REL_IDX) |-> !oe_q);
  // R9: done lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: a new request cannot end a frame early
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_bit) |=> busy_q);
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_tick,
  input  logic is_rd,
  input  logic [$clog2(FRAME_BITS)-1:0] bit_idx,
  input  logic mdio_i,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(RD_FIRST);

  logic [DATA_W-1:0] cap_q, cap_d;
  logic              take;

  assign take = rise_tick && is_rd && (bit_idx >= FIRST_IDX);

  always_comb begin
    cap_d = cap_q;
    if (take) cap_d = {cap_q[DATA_W-2:0], mdio_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end

  assign rd_data = cap_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd_sel,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        done,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic kick, last_bit, is_rd, rise_tick, bit_tick;
  logic [IDX_W-1:0] bit_idx;

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_sel(rd_sel),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .bit_tick(bit_tick), .kick(kick), .busy(busy), .last_bit(last_bit),
    .is_rd(is_rd), .bit_idx(bit_idx), .mdo(mdio_o), .oe(mdio_oe), .done(done)
  );

  mdio_mdc_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(kick), .active(busy),
    .last_bit(last_bit), .mdc(mdc), .rise_tick(rise_tick), .bit_tick(bit_tick)
  );

  mdio_rx_capture u_rx (
    .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .is_rd(is_rd),
    .bit_idx(bit_idx), .mdio_i(mdio_i), .rd_data(rd_data)
  );

  // R5: pad value and enable frozen while MDC is high inside a frame
  a_r5_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  // R1: nothing driven outside a frame
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int CLK_PER = 10;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic start, rd_sel, mdio_i;
  logic [4:0] phy_addr, reg_addr;
  logic [15:0] wr_data, rd_data;
  logic done, busy, mdc, mdio_o, mdio_oe;

  always #(CLK_PER/2) clk = ~clk;

  mdio_master #(.HALF_DIV(H)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_sel(rd_sel),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .done(done), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct {
    bit c; bit e; bit v; bit b; bit d; int idx;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] phy_reply, exp_rd;
  int falls = 0, rises = 0;
  logic prev_mdc = 1'b1;
  logic hit = 1'b0;

  function automatic exp_t idle_e();
    exp_t x; x.c = 1; x.e = 0; x.v = 1; x.b = 0; x.d = 0; x.idx = -1;
    return x;
  endfunction

  // Reference model: whole expected waveform queued when a request is taken
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = idle_e();
    end else begin
      if (q.size() == 0 && start && !cur.b) begin
        logic [63:0] fr;
        fr = {32'hFFFF_FFFF, 2'b01, (rd_sel ? 2'b10 : 2'b01), phy_addr, reg_addr, 2'b10, wr_data};
        if (rd_sel) exp_rd = phy_reply;
        for (int i = 0; i < 64; i++) begin
          exp_t x;
          x.v = fr[63-i]; x.e = !(rd_sel && i >= 46); x.b = 1; x.d = 0; x.idx = i;
          x.c = 0; for (int k = 0; k < H; k++) q.push_back(x);
          x.c = 1; for (int k = 0; k < H; k++) q.push_back(x);
        end
        begin
          exp_t z; z = idle_e(); z.d = 1; q.push_back(z);
        end
      end
      if (q.size() > 0) cur = q.pop_front();
      else cur = idle_e();
    end
  end

  // Per-cycle comparison and PHY reply model
  always @(negedge clk) begin
    cyc++;
    if (rst_n === 1'b1) begin
      hit = 0;
      n_chk++;
      if (mdc !== cur.c) begin
        hit = 1; $display("FAIL R6 mdc bit %0d: got %b exp %b", cur.idx, mdc, cur.c);
      end
      if (mdio_oe !== cur.e) begin
        hit = 1;
        if (cur.idx < 0) $display("FAIL R1 oe idle: got %b exp %b", mdio_oe, cur.e);
        else $display("FAIL R8 oe bit %0d: got %b exp %b", cur.idx, mdio_oe, cur.e);
      end
      if (cur.e && mdio_o !== cur.v) begin
        hit = 1;
        if (cur.c) $display("FAIL R5 mdo high phase bit %0d: got %b exp %b", cur.idx, mdio_o, cur.v);
        else if (cur.idx < 32) $display("FAIL R2 preamble bit %0d: got %b exp %b", cur.idx, mdio_o, cur.v);
        else if (cur.idx < 36) $display("FAIL R3 start/op bit %0d: got %b exp %b", cur.idx, mdio_o, cur.v);
        else if (cur.idx < 46) $display("FAIL R4 addr bit %0d: got %b exp %b", cur.idx, mdio_o, cur.v);
        else $display("FAIL R7 ta/data bit %0d: got %b exp %b", cur.idx, mdio_o, cur.v);
      end
      if (busy !== cur.b || done !== cur.d) begin
        hit = 1; $display("FAIL R9 busy/done: got %b/%b exp %b/%b", busy, done, cur.b, cur.d);
      end
      if (hit) n_bad++;
      if (done === 1'b1) begin
        n_chk++;
        if (rises != 64) begin
          n_bad++; $display("FAIL R6 rising edges per frame: got %0d exp 64", rises);
        end
        n_chk++;
        if (rd_data !== exp_rd) begin
          n_bad++; $display("FAIL R8 rd_data: got %h exp %h", rd_data, exp_rd);
        end
      end
      // PHY side: present bit on MDC fall, corrupt it right after the rise
      if (prev_mdc === 1'b1 && mdc === 1'b0) begin
        mdio_i = (falls >= 48) ? phy_reply[63-falls] : 1'b1;
        falls++;
      end else if (prev_mdc === 1'b0 && mdc === 1'b1) begin
        rises++;
        if (falls > 48) mdio_i = ~mdio_i;
      end
      if (busy !== 1'b1) begin falls = 0; rises = 0; end
      prev_mdc = mdc;
    end
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL R9 watchdog: got hang exp finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic xfer(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                      input logic [15:0] wd, input logic [15:0] reply, input bit poke);
    @(negedge clk);
    rd_sel = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; phy_reply = reply;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: a request while busy must be ignored
      repeat (50) @(negedge clk);
      rd_sel = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 0; rd_sel = 0; phy_addr = 0; reg_addr = 0;
    wr_data = 0; mdio_i = 1'b1; phy_reply = 0; exp_rd = 16'h0000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    n_chk++;
    if (mdc !== 1'b1 || mdio_oe !== 1'b0 || busy !== 1'b0 || done !== 1'b0 || rd_data !== 16'h0) begin
      n_bad++;
      $display("FAIL R1 reset: got mdc=%b oe=%b busy=%b done=%b rd=%h exp 1 0 0 0 0000",
               mdc, mdio_oe, busy, done, rd_data);
    end
    xfer(1'b0, 5'h01, 5'h1E, 16'hA00D, 16'h0000, 0);
    xfer(1'b1, 5'h02, 5'h03, 16'h0000, 16'h011A, 0);
    xfer(1'b1, 5'h1F, 5'h1F, 16'h0000, 16'hFFFF, 0);
    xfer(1'b1, 5'h00, 5'h00, 16'h0000, 16'h8001, 0);
    xfer(1'b0, 5'h00, 5'h00, 16'h0000, 16'h0000, 0);
    xfer(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000, 1);
    xfer(1'b1, 5'h15, 5'h0A, 16'h0000, 16'h5AA5, 1);
    repeat (10) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule